// File: doc/BRIEF.md
# Interrupt-State and Halt-Wait Unit

This unit sits on the execution side of a 32-bit core and handles three instructions from the special opcode space. The first parks the core in a wait state until an interrupt request arrives. The second copies the one-bit interrupt-enable state into a general register. The third loads that state from a general register. The pipeline supplies a decoded instruction word with a valid strobe, the value read from the source register, and the external interrupt-request line.

The unit answers with a write-back request (enable, destination index, data), a stall that holds the pipeline while the core is parked, and the current interrupt-enable flag. A read instruction produces its write-back in the same cycle in which it is accepted. A write instruction changes the enable flag at the next clock edge. A halt stalls from the cycle in which it is accepted until the first cycle in which the interrupt request is high.

Top module: `irq_halt_unit`

## Requirements
- R1: After reset, irq_en_o is 0, stall_o is 0 and wb_en_o is 0.
- R2: Only the exact word 0x70000000 is a halt. When it is accepted with irq_req_i low, stall_o is high in that same cycle. Words that differ from it in any bit do not halt.
- R3: While the unit is halted and irq_req_i is low, stall_o stays high and no instruction is accepted: there is no write-back and no change to irq_en_o.
- R4: In the first cycle in which irq_req_i is high, a halted unit drops stall_o and accepts the instruction presented in that cycle. This happens whatever the value of irq_en_o.
- R5: An instruction whose word ANDed with 0xFFFF07FF equals 0x70000024 is a state read. In the same cycle it raises wb_en_o, drives wb_idx_o with instruction bits 15:11, and drives wb_data_o with the enable flag in bit 0 and zeros in bits 31:1.
- R6: An instruction whose word ANDed with 0xFFFF07FF equals 0x70000026 is a state write. It loads bit 0 of rs_data_i into the enable flag, which is visible on irq_en_o from the next cycle. Bits 31:1 of rs_data_i have no effect.
- R7: A state read whose destination index is 0 produces no write-back.
- R8: A word that matches none of the three encodings, or any word presented with instr_valid_i low, produces no write-back and no stall, and leaves irq_en_o unchanged.
- R9: A halt accepted in a cycle in which irq_req_i is already high does not stall, and the unit is not halted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Decoded instruction word |
| instr_valid_i | input | 1 | instr_i is valid this cycle |
| rs_data_i | input | 32 | Value read from the register named in bits 15:11 |
| irq_req_i | input | 1 | External interrupt request |
| wb_en_o | output | 1 | Write-back request |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Write-back data |
| stall_o | output | 1 | Pipeline stall |
| irq_en_o | output | 1 | Current interrupt-enable flag |

## Verification
The read and write encodings are tried with several register indices in bits 15:11, which the mask ignores. Near-miss words, each one bit away from a valid encoding, show that the compare really is masked and exact. Write values that agree in bit 0 but differ in their upper bits show that only bit 0 is taken. Halt is tried in three ways: waiting several cycles with instructions queued, waking with the enable flag set and with it clear, and issuing the halt while the interrupt request is already high. Together these separate a correct wake condition from one gated by the enable flag or by a one-cycle delay.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned IDX_LO = 11;

  localparam logic [XLEN-1:0] HALT_WORD = 32'h7000_0000;
  localparam logic [XLEN-1:0] IE_MASK   = 32'hFFFF_07FF;
  localparam logic [XLEN-1:0] IE_RD_PAT = 32'h7000_0024;
  localparam logic [XLEN-1:0] IE_WR_PAT = 32'h7000_0026;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_HALT = 2'd1,
    OP_RDIE = 2'd2,
    OP_WRIE = 2'd3
  } ie_op_e;
endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
  import irq_halt_pkg::*;
(
  input  logic [XLEN-1:0]   instr_i,
  output ie_op_e            op_o,
  output logic [REG_AW-1:0] reg_idx_o
);
  always_comb begin
    op_o = OP_NONE;
    if (instr_i == HALT_WORD)                     op_o = OP_HALT;
    else if ((instr_i & IE_MASK) == IE_RD_PAT)    op_o = OP_RDIE;
    else if ((instr_i & IE_MASK) == IE_WR_PAT)    op_o = OP_WRIE;
  end

  assign reg_idx_o = instr_i[IDX_LO +: REG_AW];
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic instr_valid_i,
  input  logic halt_op_i,
  input  logic irq_req_i,
  output logic accept_o,
  output logic stall_o
);
  logic halted_q, halted_d, halt_issue;

  // parked and no wake request: nothing gets in
  assign accept_o   = instr_valid_i & ~(halted_q & ~irq_req_i);
  assign halt_issue = accept_o & halt_op_i;
  assign halted_d   = (halted_q | halt_issue) & ~irq_req_i;
  assign stall_o    = halted_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halted_q <= 1'b0;
    else         halted_q <= halted_d;
  end

  assert_stall_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !irq_req_i) |=> (stall_o || irq_req_i));

  assert_no_accept_parked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !irq_req_i) |-> !accept_o);

  assert_wake_on_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |=> !halted_q);

  assert_no_stall_with_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_i |-> !stall_o);
endmodule

// File: rtl/irq_en_state.sv
module irq_en_state
  import irq_halt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  ie_op_e            op_i,
  input  logic [REG_AW-1:0] reg_idx_i,
  input  logic [XLEN-1:0]   rs_data_i,
  output logic              wb_en_o,
  output logic [REG_AW-1:0] wb_idx_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              irq_en_o
);
  logic irq_en_q, wr_fire;
  logic unused_rs_hi;

  assign unused_rs_hi = ^rs_data_i[XLEN-1:1];
  assign wr_fire      = accept_i & (op_i == OP_WRIE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_en_q <= 1'b0;
    else if (wr_fire) irq_en_q <= rs_data_i[0];
  end

  // register zero never written
  assign wb_en_o   = accept_i & (op_i == OP_RDIE) & (reg_idx_i != '0);
  assign wb_idx_o  = reg_idx_i;
  assign wb_data_o = wb_en_o ? {{(XLEN-1){1'b0}}, irq_en_q} : '0;
  assign irq_en_o  = irq_en_q;

  assert_wr_loads_bit0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> (irq_en_o == $past(rs_data_i[0])));

  assert_en_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_fire |=> $stable(irq_en_o));

  assert_rd_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_data_o[XLEN-1:1] == '0 && wb_data_o[0] == irq_en_o));

  assert_no_r0_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o != '0));
endmodule

// File: rtl/irq_halt_unit.sv
module irq_halt_unit
  import irq_halt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   instr_i,
  input  logic              instr_valid_i,
  input  logic [XLEN-1:0]   rs_data_i,
  input  logic              irq_req_i,
  output logic              wb_en_o,
  output logic [REG_AW-1:0] wb_idx_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              stall_o,
  output logic              irq_en_o
);
  ie_op_e            op;
  logic [REG_AW-1:0] reg_idx;
  logic              accept;

  irq_op_decode u_dec (
    .instr_i   (instr_i),
    .op_o      (op),
    .reg_idx_o (reg_idx)
  );

  irq_halt_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .halt_op_i     (op == OP_HALT),
    .irq_req_i     (irq_req_i),
    .accept_o      (accept),
    .stall_o       (stall_o)
  );

  irq_en_state u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .op_i      (op),
    .reg_idx_i (reg_idx),
    .rs_data_i (rs_data_i),
    .wb_en_o   (wb_en_o),
    .wb_idx_o  (wb_idx_o),
    .wb_data_o (wb_data_o),
    .irq_en_o  (irq_en_o)
  );

  assert_stall_blocks_wb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !wb_en_o);
endmodule

// File: tb/sim_irq_halt_unit.sv
module sim_irq_halt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic        valid = 1'b0;
  logic [31:0] rs = '0;
  logic        irq = 1'b0;
  logic        wb_en, stall, irq_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic        wb_en;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        stall;
    logic        en;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  logic m_en   = 1'b0;
  logic m_halt = 1'b0;

  always #10 clk = ~clk;

  irq_halt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .instr_valid_i(valid),
    .rs_data_i(rs), .irq_req_i(irq), .wb_en_o(wb_en), .wb_idx_o(wb_idx),
    .wb_data_o(wb_data), .stall_o(stall), .irq_en_o(irq_en)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // driver: one call per cycle, model built from the requirements
  task automatic step(input logic [31:0] w, input logic v, input logic [31:0] r, input logic q, input string req);
    exp_t e;
    logic acc, is_h, is_r, is_w;
    @(negedge clk);
    instr = w; valid = v; rs = r; irq = q;
    acc  = v & ~(m_halt & ~q);
    is_h = (w == 32'h7000_0000);
    is_r = ((w & 32'hFFFF_07FF) == 32'h7000_0024);
    is_w = ((w & 32'hFFFF_07FF) == 32'h7000_0026);
    e.wb_en = acc & is_r & (w[15:11] != 5'd0);
    e.idx   = w[15:11];
    e.data  = e.wb_en ? {31'b0, m_en} : 32'b0;
    e.stall = (m_halt | (acc & is_h)) & ~q;
    e.en    = m_en;
    e.req   = req;
    exp_q.push_back(e);
    if (acc & is_w) m_en = r[0];
    m_halt = (m_halt | (acc & is_h)) & ~q;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "wb_en", {31'b0, wb_en}, {31'b0, e.wb_en});
        if (e.wb_en) chk(e.req, "wb_idx", {27'b0, wb_idx}, {27'b0, e.idx});
        chk(e.req, "wb_data", wb_data, e.data);
        chk(e.req, "stall", {31'b0, stall}, {31'b0, e.stall});
        chk(e.req, "irq_en", {31'b0, irq_en}, {31'b0, e.en});
      end
    end
  end

  function automatic logic [31:0] rd(input int idx);
    return 32'h7000_0024 | (32'(idx) << 11);
  endfunction
  function automatic logic [31:0] wr(input int idx);
    return 32'h7000_0026 | (32'(idx) << 11);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R1 reset state
    chk("R1", "irq_en", {31'b0, irq_en}, 32'd0);
    chk("R1", "stall", {31'b0, stall}, 32'd0);
    chk("R1", "wb_en", {31'b0, wb_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    step(rd(3), 1, 0, 0, "R5");
    step(wr(4), 1, 32'h1, 0, "R6");
    step(rd(7), 1, 0, 0, "R5");
    step(wr(31), 1, 32'hFFFF_FFFE, 0, "R6");
    step(rd(1), 1, 0, 0, "R6");
    step(wr(9), 1, 32'h8000_0001, 0, "R6");
    step(rd(31), 1, 0, 0, "R5");
    step(rd(0), 1, 0, 0, "R7");
    step(32'h7000_0025, 1, 32'h0, 0, "R8");
    step(32'h7001_0026, 1, 32'h0, 0, "R8");
    step(32'h7000_0001, 1, 32'h0, 0, "R2");
    step(32'h0000_0000, 1, 32'h0, 0, "R8");
    step(wr(2), 0, 32'h0, 0, "R8");
    step(rd(2), 0, 32'h0, 0, "R8");
    // halt, wait with instructions queued, wake with enable 1
    step(32'h7000_0000, 1, 0, 0, "R2");
    step(wr(5), 1, 32'h0, 0, "R3");
    step(rd(6), 1, 32'h0, 0, "R3");
    step(wr(5), 1, 32'h0, 0, "R3");
    step(rd(5), 1, 0, 1, "R4");
    step(32'h0, 0, 0, 0, "R4");
    // wake with enable 0
    step(wr(8), 1, 32'h0, 0, "R6");
    step(32'h7000_0000, 1, 0, 0, "R2");
    step(32'h0, 0, 0, 0, "R3");
    step(32'h0, 0, 0, 1, "R4");
    step(rd(10), 1, 0, 0, "R4");
    // halt while irq already high
    step(32'h7000_0000, 1, 0, 1, "R9");
    step(rd(11), 1, 0, 0, "R9");
    step(32'h0, 0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule